// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers four reset causes (a power-on strobe, a supply-low level from an external comparator, an overflow of its own watchdog counter, and an illegal-opcode strobe from the processor's decoder) into one timed recovery sequence. The sequence is counted in cycles of the reference clock that drives the block. It drives an active-low external reset pin and gates the module clocks. It also decides when the processor may begin fetching its reset vector.

Power-on and supply-low recovery both begin with a long stabilization hold. During that hold the clocks stay gated and the pin stays low. Once the hold ends, the pin is released at a short fixed offset and the processor at a longer one. Watchdog and illegal-opcode recovery skip the stabilization hold and use only the two release offsets. A four-bit status register records which causes have occurred since the last power-on. It is read directly from its flops. Software keeps the watchdog quiet by pulsing a service write while the processor runs.

Top module: `rstseq_top`

## Requirements
- R1: While `rst` is high, `rst_pin_n`, `clk_en` and `cpu_run` are all 0, and `rst_status` is 4'b0011. Bit 0 is the power-on flag, bit 1 the supply-low flag, bit 2 the watchdog flag and bit 3 the illegal-opcode flag. Releasing `rst` starts the power-on sequence.
- R2: After a power-on request is sampled, `clk_en` stays 0 for exactly STAB_CYC cycles.
- R3: `rst_pin_n` rises exactly PIN_OFS cycles after the stabilization hold ends, and it is never high while `clk_en` is 0.
- R4: `cpu_run` rises exactly CPU_OFS cycles after the stabilization hold ends, and only while the pin is released and the clocks are enabled.
- R5: A power-on request sets `rst_status` to exactly 4'b0011.
- R6: While `lv_low` is high, the pin is low, the clocks are gated and bit 1 is set. The stabilization hold begins on the cycle after `lv_low` falls. The other status bits are unchanged.
- R7: If WDOG_LIMIT cycles of `cpu_run` pass with no service write, a reset occurs. It sets bit 2 and runs the short sequence: the clocks stay enabled, the pin is released after PIN_OFS cycles and the processor after CPU_OFS cycles.
- R8: A `wdog_wr` pulse while running restarts the watchdog count, so an overflow comes exactly WDOG_LIMIT cycles after the last write.
- R9: `ill_req` while `cpu_run` is high causes the short sequence and sets bit 3. While the processor is held, `ill_req` is ignored.
- R10: Watchdog, illegal-opcode and supply-low resets only set their own bit. No status bit falls except through a power-on request.
- R11: A power-on or supply-low request that arrives mid-sequence restarts the sequence from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power-on event |
| por_req | input | 1 | Power-on reset strobe |
| lv_low | input | 1 | Supply below rising trip level (level) |
| wdog_wr | input | 1 | Watchdog service write strobe |
| ill_req | input | 1 | Illegal-opcode strobe from the decoder |
| rst_pin_n | output | 1 | External reset pin drive, active low |
| clk_en | output | 1 | Clock enable for the processor and modules |
| cpu_run | output | 1 | Processor released to fetch its reset vector |
| rst_status | output | 4 | Reset cause flags {illegal, watchdog, supply-low, power-on} |

## Verification
The bench counts, one cycle at a time, how long the clocks stay gated, the pin stays low and the processor stays held after each kind of reset. An off-by-one in the hold counter or in either release offset therefore shows up as a wrong count. It lets the watchdog run out both from sequence release and from a randomly spaced last service write. A counter that missed the clear, or that overflowed one cycle early or late, would give the wrong run length. It fires an illegal opcode while the processor is held, which must change neither the timing nor the flags. It also restarts a sequence in the middle of both the long hold and the short release phase. A design that ignored the restart would release the pin early, and one that cleared flags on every reset would lose the accumulated watchdog and illegal-opcode bits.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        SQ_RUN  = 2'd0,
        SQ_LOWV = 2'd1,
        SQ_STAB = 2'd2,
        SQ_POST = 2'd3
    } seq_state_e;

    localparam int ST_W   = 4;
    localparam int ST_POR = 0;
    localparam int ST_LVI = 1;
    localparam int ST_WDG = 2;
    localparam int ST_ILL = 3;

    localparam logic [ST_W-1:0] POR_STATUS = 4'b0011;

    typedef struct packed {
        logic ill;
        logic wdg;
        logic lvi;
        logic por;
    } cause_t;

    // Power-on wipes the flags to its fixed pattern; every other cause only ORs in its bit.
    function automatic logic [ST_W-1:0] status_next(input logic [ST_W-1:0] cur, input cause_t c);
        logic [ST_W-1:0] s;
        s = c.por ? POR_STATUS : cur;
        if (c.lvi) s[ST_LVI] = 1'b1;
        if (c.wdg) s[ST_WDG] = 1'b1;
        if (c.ill) s[ST_ILL] = 1'b1;
        return s;
    endfunction

    // The state a request sends the sequencer to; the supply-low level dominates.
    function automatic seq_state_e entry_state(input cause_t c);
        if (c.lvi)      return SQ_LOWV;
        else if (c.por) return SQ_STAB;
        else            return SQ_POST;
    endfunction

    function automatic logic req_pending(input cause_t c);
        return c.por | c.lvi | c.wdg | c.ill;
    endfunction

endpackage

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic svc_wr,
    output logic ovf
);
    localparam int WW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [WW-1:0] cnt;

    assign ovf = run && !svc_wr && (cnt == WW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (svc_wr || ovf) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + WW'(1);
        end
    end
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            por_req,
    input  logic            lv_low,
    input  logic            wd_ovf,
    input  logic            ill_req,
    input  logic            run,
    output cause_t          cause,
    output logic [ST_W-1:0] status
);
    always_comb begin
        cause.por = por_req;
        cause.lvi = lv_low;
        cause.wdg = wd_ovf;
        cause.ill = ill_req && run;   // a held processor executes nothing
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= POR_STATUS;
        end else begin
            status <= status_next(status, cause);
        end
    end
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC = 4096,
    parameter int PIN_OFS  = 32,
    parameter int CPU_OFS  = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  cause_t cause,
    output logic   rst_pin_n,
    output logic   clk_en,
    output logic   cpu_run
);
    localparam int SPAN = (STAB_CYC > CPU_OFS) ? STAB_CYC : CPU_OFS;
    localparam int CW   = $clog2(SPAN + 1);

    seq_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt + CW'(1);
        if (req_pending(cause)) begin
            st_n  = entry_state(cause);
            cnt_n = '0;
        end else begin
            unique case (st)
                SQ_RUN: cnt_n = '0;
                SQ_LOWV: begin
                    st_n  = SQ_STAB;
                    cnt_n = '0;
                end
                SQ_STAB: if (cnt == CW'(STAB_CYC - 1)) begin
                    st_n  = SQ_POST;
                    cnt_n = '0;
                end
                SQ_POST: if (cnt == CW'(CPU_OFS - 1)) begin
                    st_n  = SQ_RUN;
                    cnt_n = '0;
                end
                default: begin
                    st_n  = SQ_STAB;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_STAB;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    assign clk_en    = (st == SQ_RUN) || (st == SQ_POST);
    assign rst_pin_n = (st == SQ_RUN) || ((st == SQ_POST) && (cnt >= CW'(PIN_OFS)));
    assign cpu_run   = (st == SQ_RUN);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC   = 4096,
    parameter int PIN_OFS    = 32,
    parameter int CPU_OFS    = 64,
    parameter int WDOG_LIMIT = 1024
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            por_req,
    input  logic            lv_low,
    input  logic            wdog_wr,
    input  logic            ill_req,
    output logic            rst_pin_n,
    output logic            clk_en,
    output logic            cpu_run,
    output logic [ST_W-1:0] rst_status
);
    cause_t cause;
    logic   wd_ovf;

    rstseq_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .run    (cpu_run),
        .svc_wr (wdog_wr),
        .ovf    (wd_ovf)
    );

    rstseq_cause u_cause (
        .clk     (clk),
        .rst     (rst),
        .por_req (por_req),
        .lv_low  (lv_low),
        .wd_ovf  (wd_ovf),
        .ill_req (ill_req),
        .run     (cpu_run),
        .cause   (cause),
        .status  (rst_status)
    );

    rstseq_timer #(
        .STAB_CYC (STAB_CYC),
        .PIN_OFS  (PIN_OFS),
        .CPU_OFS  (CPU_OFS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cause     (cause),
        .rst_pin_n (rst_pin_n),
        .clk_en    (clk_en),
        .cpu_run   (cpu_run)
    );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_req,
    input logic       lv_low,
    input logic       ill_req,
    input logic       rst_pin_n,
    input logic       clk_en,
    input logic       cpu_run,
    input logic [3:0] rst_status
);
    assert_pin_after_clk_R3: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> !rst_pin_n);

    assert_run_needs_release_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_run |-> (rst_pin_n && clk_en));

    assert_por_status_R5: assert property (@(posedge clk) disable iff (rst)
        (por_req && !cpu_run) |=> (rst_status == 4'b0011));

    assert_lowv_hold_R6: assert property (@(posedge clk) disable iff (rst)
        lv_low |=> (!clk_en && !rst_pin_n && rst_status[1]));

    assert_ill_held_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (ill_req && !cpu_run && !por_req) |=> (rst_status[3] == $past(rst_status[3])));

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !por_req |=> ((rst_status & $past(rst_status)) == $past(rst_status)));

    assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
        (por_req || lv_low) |=> (!rst_pin_n && !cpu_run && !clk_en));
endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .por_req    (por_req),
    .lv_low     (lv_low),
    .ill_req    (ill_req),
    .rst_pin_n  (rst_pin_n),
    .clk_en     (clk_en),
    .cpu_run    (cpu_run),
    .rst_status (rst_status)
);

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;
    localparam int STAB = 4096;
    localparam int PIN  = 32;
    localparam int CPU  = 64;
    localparam int WDL  = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por_req = 1'b0;
    logic       lv_low = 1'b0;
    logic       wdog_wr = 1'b0;
    logic       ill_req = 1'b0;
    logic       rst_pin_n, clk_en, cpu_run;
    logic [3:0] rst_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rstseq_top dut (
        .clk(clk), .rst(rst), .por_req(por_req), .lv_low(lv_low),
        .wdog_wr(wdog_wr), .ill_req(ill_req), .rst_pin_n(rst_pin_n),
        .clk_en(clk_en), .cpu_run(cpu_run), .rst_status(rst_status)
    );

    // Expected counts: 'pre' cycles of supply-low hold, 'long' selects the stabilization hold,
    // 'used' cycles of the sequence already elapsed.
    function automatic int exp_off(input int pre, input bit long, input int used);
        return pre + (long ? STAB : 0) - used;
    endfunction
    function automatic int exp_pin(input int pre, input bit long, input int used);
        return pre + (long ? STAB : 0) + PIN - used;
    endfunction
    function automatic int exp_hold(input int pre, input bit long, input int used);
        return pre + (long ? STAB : 0) + CPU - used;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic measure(input int e_off, input int e_pin, input int e_hold,
                           input string t_off, input string t_pin, input string t_hold);
        int n_off = 0, n_pin = 0, n_hold = 0, guard = 0;
        while (!cpu_run && guard < 20000) begin
            if (!clk_en)    n_off++;
            if (!rst_pin_n) n_pin++;
            n_hold++;
            guard++;
            @(negedge clk);
        end
        chk(n_off == e_off, t_off, n_off, e_off);
        chk(n_pin == e_pin, t_pin, n_pin, e_pin);
        chk(n_hold == e_hold, t_hold, n_hold, e_hold);
    endtask

    task automatic run_len(output int n);
        n = 0;
        while (cpu_run && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_por();
        @(negedge clk); por_req = 1'b1;
        @(negedge clk); por_req = 1'b0;
    endtask

    task automatic pulse_ill();
        ill_req = 1'b1;
        @(negedge clk); ill_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int unsigned sd;
        bit stayed;
        sd = $urandom(32'd20240611);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!rst_pin_n, "R1 pin", rst_pin_n, 0);
        chk(!clk_en, "R1 clk_en", clk_en, 0);
        chk(!cpu_run, "R1 cpu_run", cpu_run, 0);
        chk(rst_status == 4'b0011, "R1 status", rst_status, 4'b0011);
        rst = 1'b0;
        measure(exp_off(0, 1, 0), exp_pin(0, 1, 0), exp_hold(0, 1, 0), "R2", "R3", "R4");
        chk(rst_status == 4'b0011, "R5 status after power-on", rst_status, 4'b0011);

        // R7: watchdog overflow from release
        run_len(n);
        chk(n == WDL, "R7 run length", n, WDL);
        measure(exp_off(0, 0, 0), exp_pin(0, 0, 0), exp_hold(0, 0, 0), "R7 off", "R7 pin", "R7 hold");
        chk(rst_status == 4'b0111, "R7 R10 status", rst_status, 4'b0111);

        // R8: random service writes keep it running
        stayed = 1'b1;
        for (int i = 0; i < 6; i++) begin
            int gap;
            gap = 1 + int'($urandom % (WDL - 2));
            repeat (gap) begin
                @(negedge clk);
                if (!cpu_run) stayed = 1'b0;
            end
            wdog_wr = 1'b1;
            @(negedge clk); wdog_wr = 1'b0;
            if (!cpu_run) stayed = 1'b0;
        end
        chk(stayed, "R8 serviced stays running", stayed, 1);
        run_len(n);
        chk(n == WDL, "R8 overflow after last write", n, WDL);
        measure(exp_off(0, 0, 0), exp_pin(0, 0, 0), exp_hold(0, 0, 0), "R8 off", "R8 pin", "R8 hold");

        // R9: illegal opcode while running
        repeat (3) @(negedge clk);
        pulse_ill();
        measure(exp_off(0, 0, 0), exp_pin(0, 0, 0), exp_hold(0, 0, 0), "R9 off", "R9 pin", "R9 hold");
        chk(rst_status == 4'b1111, "R9 R10 status", rst_status, 4'b1111);

        // R5 and R9: power-on clears, illegal opcode during hold ignored
        pulse_por();
        chk(rst_status == 4'b0011, "R5 clears flags", rst_status, 4'b0011);
        repeat (10) @(negedge clk);
        pulse_ill();
        chk(rst_status == 4'b0011, "R9 ignored while held", rst_status, 4'b0011);
        measure(exp_off(0, 1, 11), exp_pin(0, 1, 11), exp_hold(0, 1, 11), "R9 held off", "R9 held pin", "R9 held hold");

        // R6: supply-low with random length, illegal flag kept
        repeat (2) @(negedge clk);
        pulse_ill();
        measure(exp_off(0, 0, 0), exp_pin(0, 0, 0), exp_hold(0, 0, 0), "R9 off 2", "R9 pin 2", "R9 hold 2");
        begin
            int h;
            h = 5 + int'($urandom % 50);
            lv_low = 1'b1;
            repeat (h) @(negedge clk);
            chk(!clk_en && !rst_pin_n, "R6 held during low supply", {clk_en, rst_pin_n}, 0);
            lv_low = 1'b0;
        end
        measure(exp_off(1, 1, 0), exp_pin(1, 1, 0), exp_hold(1, 1, 0), "R6 off", "R6 pin", "R6 hold");
        chk(rst_status == 4'b1011, "R6 R10 status", rst_status, 4'b1011);

        // R11: power-on restarts a running hold
        pulse_por();
        repeat (100) @(negedge clk);
        pulse_por();
        measure(exp_off(0, 1, 0), exp_pin(0, 1, 0), exp_hold(0, 1, 0), "R11 off", "R11 pin", "R11 hold");

        // R11: power-on during the short release phase
        repeat (4) @(negedge clk);
        pulse_ill();
        repeat (5) @(negedge clk);
        pulse_por();
        measure(exp_off(0, 1, 0), exp_pin(0, 1, 0), exp_hold(0, 1, 0), "R11 post off", "R11 post pin", "R11 post hold");
        chk(rst_status == 4'b0011, "R11 status", rst_status, 4'b0011);

        // R11 with R6: supply dip during stabilization hold
        pulse_por();
        repeat (20) @(negedge clk);
        lv_low = 1'b1;
        repeat (3) @(negedge clk);
        lv_low = 1'b0;
        measure(exp_off(1, 1, 0), exp_pin(1, 1, 0), exp_hold(1, 1, 0), "R11 lv off", "R11 lv pin", "R11 lv hold");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule